// File: doc/BRIEF.md
# Serial Character Receiver with Selectable Parity

This block receives asynchronous serial characters on a single input line. A tick input that pulses at sixteen times the bit rate paces all sampling. The line is synchronised to the system clock. The block finds a start bit on a falling edge and confirms it half a bit later. It then samples eight data bits, least significant first, an optional parity bit and one stop bit. Every other sample lands in the middle of its bit.

Each finished character goes into one holding register and raises a ready flag. A host takes the character with a read strobe, which lowers the ready flag. Parity, framing and overrun faults are kept as separate sticky flags. Only a status-clear strobe resets them. The parity behaviour is chosen by a three-bit mode input, which the block captures when it confirms a start bit.

Top module: `uart_rx_par`

## Requirements
- R1: A frame is start (0), then eight data bits with the least significant bit first, then a parity bit when parity is enabled, then a stop bit. When the stop bit is sampled, the data goes into `rx_data` and `rx_ready` goes to 1.
- R2: A start is accepted only if the line is still low eight ticks after the falling edge is seen. A low pulse shorter than that returns the block to idle, produces no character and leaves `rx_ready` unchanged.
- R3: A one-cycle `rd_strobe` clears `rx_ready` and leaves all three error flags unchanged.
- R4: If a character completes while `rx_ready` is 1 and no read happens in that cycle, `err_overrun` is set and the new character replaces `rx_data`. A read does not clear `err_overrun`.
- R5: With `par_sel` = 3'b001 (even), `err_parity` is set when the parity bit plus the number of ones in the data is odd.
- R6: With `par_sel` = 3'b010 (odd), `err_parity` is set when the parity bit plus the number of ones in the data is even.
- R7: With `par_sel` = 3'b011 (mark), `err_parity` is set if the parity bit is 0. With `par_sel` = 3'b100 (space), it is set if the parity bit is 1.
- R8: With `par_sel` = 3'b000 (none), the frame has no parity slot and `err_parity` is never set. The values 3'b101 to 3'b111 also mean none.
- R9: A stop bit sampled low sets `err_frame`. The character is still delivered.
- R10: The error flags stay set until a `clr_status` pulse, which clears all three. If an error occurs in the same cycle as the clear, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd_line | input | 1 | Serial input line, idle high |
| par_sel | input | 3 | Parity mode: 000 none, 001 even, 010 odd, 011 mark, 100 space |
| rd_strobe | input | 1 | Host read of the held character; clears ready |
| clr_status | input | 1 | Clears the parity, framing and overrun flags |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The hardest case to reach is proving that mode none really drops the parity slot. A receiver that wrongly waits for a parity bit still reads a well-spaced frame without complaint: it takes the high stop bit as parity and then reads the idle line as the stop bit. To expose this, the bench sends two frames back to back with no idle gap. A receiver that wrongly expects a parity slot would then sample the next start bit as its stop bit and raise a framing error. The bench also drives a start pulse shorter than half a bit, to show that a glitch produces no character.

// File: rtl/uart_rx_par.sv
module uart_rx_par #(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_16x,
  input  logic                 rxd_line,
  input  logic [2:0]           par_sel,
  input  logic                 rd_strobe,
  input  logic                 clr_status,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_ready,
  output logic                 err_parity,
  output logic                 err_frame,
  output logic                 err_overrun
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_BITS);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOP  = BW'(DATA_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                  state;
  logic [1:0]           sync;
  logic                 last_line, pbit, perr;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic [2:0]           mode_q;

  wire line   = sync[1];
  wire par_on = (mode_q >= 3'd1) && (mode_q <= 3'd4);
  wire at_end = tick_16x && (cnt == LAST);
  wire done   = at_end && (state == S_STOP);

  always_comb begin
    case (mode_q)
      3'd1:    perr = ^shreg ^ pbit;
      3'd2:    perr = ~(^shreg ^ pbit);
      3'd3:    perr = ~pbit;
      3'd4:    perr = pbit;
      default: perr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      last_line <= 1'b1;
      state     <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      mode_q    <= 3'd0;
    end else begin
      sync <= {sync[0], rxd_line};
      if (tick_16x) begin
        last_line <= line;
        cnt       <= cnt + 1'b1;
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (last_line && !line) state <= S_START;
          end
          S_START: if (cnt == MID) begin
            cnt <= '0;
            if (!line) begin
              state  <= S_DATA;
              bitn   <= '0;
              mode_q <= par_sel;
            end else begin
              state <= S_IDLE;
            end
          end
          S_DATA: if (cnt == LAST) begin
            shreg <= {line, shreg[DATA_BITS-1:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == TOP) state <= par_on ? S_PAR : S_STOP;
          end
          S_PAR: if (cnt == LAST) begin
            pbit  <= line;
            state <= S_STOP;
          end
          S_STOP: if (cnt == LAST) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (done) rx_data <= shreg;
      rx_ready    <= done | (rx_ready & ~rd_strobe);
      err_overrun <= (err_overrun & ~clr_status) | (done & rx_ready & ~rd_strobe);
      err_parity  <= (err_parity & ~clr_status) | (done & perr);
      err_frame   <= (err_frame & ~clr_status) | (done & ~line);
    end
  end

  p_ready_on_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_ready);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> !rx_ready);
  p_read_keeps_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !clr_status) |=> err_overrun);
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_ready && !rd_strobe) |=> err_overrun);
  p_no_par_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAR) |-> par_on);
  p_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !line) |=> err_frame);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !done) |=> (!err_parity && !err_frame && !err_overrun));
endmodule

// File: tb/tb_uart_rx_par.sv
module tb_uart_rx_par;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       rxd_line = 1'b1;
  logic [2:0] par_sel = 3'd0;
  logic       rd_strobe = 1'b0;
  logic       clr_status = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;
  logic [1:0] div = 2'd0;
  int vectors = 0;
  int misses  = 0;
  bit ended   = 1'b0;

  localparam int BITCLK = 64;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div      <= div + 2'd1;
    tick_16x <= (div == 2'd3);
  end

  uart_rx_par dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd_line(rxd_line),
    .par_sel(par_sel), .rd_strobe(rd_strobe), .clr_status(clr_status),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v);
    rxd_line = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit has_par, input logic pb,
                      input logic stopb, input int gap);
    @(negedge clk);
    hold(1'b0);
    for (int i = 0; i < 8; i++) hold(d[i]);
    if (has_par) hold(pb);
    hold(stopb);
    rxd_line = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset ready", {7'd0, rx_ready}, 8'd0);
    check("R10 reset errors", {5'd0, err_parity, err_frame, err_overrun}, 8'd0);
    check("R1 reset data", rx_data, 8'h00);
  endtask

  task automatic t_plain();
    par_sel = 3'd0;
    send(8'hA5, 1'b0, 1'b0, 1'b1, BITCLK);
    check("R1 data lsb first", rx_data, 8'hA5);
    check("R1 ready", {7'd0, rx_ready}, 8'd1);
    check("R8 no parity err", {7'd0, err_parity}, 8'd0);
  endtask

  task automatic t_read();
    pulse_rd();
    check("R3 ready cleared", {7'd0, rx_ready}, 8'd0);
    check("R3 data kept", rx_data, 8'hA5);
  endtask

  task automatic t_even();
    par_sel = 3'd1;
    send(8'h07, 1'b1, 1'b1, 1'b1, BITCLK);
    check("R5 even good", {rx_data[6:0], err_parity}, {7'h07, 1'b0});
    pulse_rd();
    send(8'h07, 1'b1, 1'b0, 1'b1, BITCLK);
    check("R5 even bad", {7'd0, err_parity}, 8'd1);
    pulse_rd();
    check("R3 read keeps parity err", {7'd0, err_parity}, 8'd1);
    pulse_clr();
    check("R10 clear parity", {7'd0, err_parity}, 8'd0);
  endtask

  task automatic t_odd();
    par_sel = 3'd2;
    send(8'h03, 1'b1, 1'b1, 1'b1, BITCLK);
    check("R6 odd good", {7'd0, err_parity}, 8'd0);
    pulse_rd();
    send(8'h03, 1'b1, 1'b0, 1'b1, BITCLK);
    check("R6 odd bad", {7'd0, err_parity}, 8'd1);
    pulse_rd(); pulse_clr();
  endtask

  task automatic t_mark_space();
    par_sel = 3'd3;
    send(8'h3C, 1'b1, 1'b1, 1'b1, BITCLK);
    check("R7 mark good", {7'd0, err_parity}, 8'd0);
    pulse_rd();
    send(8'h3C, 1'b1, 1'b0, 1'b1, BITCLK);
    check("R7 mark bad", {7'd0, err_parity}, 8'd1);
    pulse_rd(); pulse_clr();
    par_sel = 3'd4;
    send(8'hC3, 1'b1, 1'b0, 1'b1, BITCLK);
    check("R7 space good", {7'd0, err_parity}, 8'd0);
    pulse_rd();
    send(8'hC3, 1'b1, 1'b1, 1'b1, BITCLK);
    check("R7 space bad", {7'd0, err_parity}, 8'd1);
    pulse_rd(); pulse_clr();
  endtask

  task automatic t_none_b2b();
    par_sel = 3'd6;
    send(8'h81, 1'b0, 1'b0, 1'b1, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b1, BITCLK);
    check("R8 b2b data", rx_data, 8'h5A);
    check("R8 b2b no frame/parity err", {6'd0, err_frame, err_parity}, 8'd0);
    pulse_rd(); pulse_clr();
  endtask

  task automatic t_overrun();
    par_sel = 3'd0;
    send(8'h11, 1'b0, 1'b0, 1'b1, BITCLK);
    send(8'h22, 1'b0, 1'b0, 1'b1, BITCLK);
    check("R4 overrun set", {7'd0, err_overrun}, 8'd1);
    check("R4 newest kept", rx_data, 8'h22);
    pulse_rd();
    check("R4 read keeps overrun", {7'd0, err_overrun}, 8'd1);
    pulse_clr();
    check("R10 clear overrun", {7'd0, err_overrun}, 8'd0);
  endtask

  task automatic t_frame();
    send(8'h66, 1'b0, 1'b0, 1'b0, BITCLK);
    check("R9 frame err", {7'd0, err_frame}, 8'd1);
    check("R9 char delivered", {rx_data[6:0], rx_ready}, {7'h66, 1'b1});
    pulse_rd();
    send(8'h99, 1'b0, 1'b0, 1'b1, BITCLK);
    check("R10 frame sticky", {7'd0, err_frame}, 8'd1);
    pulse_rd(); pulse_clr();
    check("R10 frame cleared", {7'd0, err_frame}, 8'd0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rxd_line = 1'b0;
    repeat (12) @(negedge clk);
    rxd_line = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    check("R2 glitch no char", {7'd0, rx_ready}, 8'd0);
    check("R2 glitch data kept", rx_data, 8'h99);
    send(8'h4E, 1'b0, 1'b0, 1'b1, BITCLK);
    check("R2 valid after glitch", rx_data, 8'h4E);
    pulse_rd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (BITCLK) @(negedge clk);
    t_reset();
    t_plain();
    t_read();
    t_even();
    t_odd();
    t_mark_space();
    t_none_b2b();
    t_overrun();
    t_frame();
    t_glitch();
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule